// File: doc/BRIEF.md
# Clear Channel Assessment Evaluator

This block decides whether a radio channel is occupied. A stream of raw signal-strength samples arrives with a valid strobe, and the block keeps the most recent one. A start pulse launches a measurement. The block first lets a programmable number of timebase ticks pass. It then adds the held sample into an accumulator on every tick of a programmable window and divides the total by the window length. The average gets a signed calibration offset, is clamped into a 7-bit strength code, and is compared with a threshold. The block then pulses done and reports busy or clear.

Separately, a packet-end strobe latches the calibrated, clamped value of the held sample into the reported strength output. That output keeps its value between such events. Raw samples and the reported code both use a 1 dB step scale. Code 0 stands for -127 dBm or weaker, and code 127 stands for 0 dBm or stronger.

Top module: `cca_eval`

## Requirements
- R1: After reset, done_o, busy_o and rssi_o are all 0 and the internal threshold register holds 0xFF.
- R2: A start_i pulse while idle captures delay_i and length_i. The next delay_i ticks contribute nothing. On each of the following N ticks, where N is length_i or 1 when length_i is 0, the most recently strobed sample is added to the window sum.
- R3: The average is floor(sum / N). With length_i equal to 0, the single sample held at the first tick after the delay is the result.
- R4: offset_i is a 6-bit two's complement value (-32 to +31) and is added to the average.
- R5: The calibrated value is clamped to the range 0..127 before it is reported on rssi_o (0 = -127 dBm or below, 127 = 0 dBm or above) and compared, so the offset never wraps the result.
- R6: busy_o is 1 only when the clamped 7-bit value, zero-extended, is strictly greater than the 8-bit threshold. Equality reports clear.
- R7: The threshold is loaded from thr_i when thr_we_i is high. At its reset value of 0xFF every measurement reports clear.
- R8: done_o is high for exactly one cycle per measurement. busy_o and rssi_o carry the result in that same cycle, and busy_o changes only when done_o is high.
- R9: A start_i pulse while a measurement is in progress is ignored and causes no second result.
- R10: A pkt_end_i pulse latches clamp(held sample + offset_i) into rssi_o on the next cycle. When no pulse or measurement end occurs, rssi_o holds its value. A measurement result takes priority if both coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_valid_i | input | 1 | Strobe for sample_i |
| sample_i | input | 8 | Raw signal-strength sample, 1 dB code |
| tick_i | input | 1 | Timebase tick |
| start_i | input | 1 | Begin a measurement |
| pkt_end_i | input | 1 | End of packet reception: latch strength |
| delay_i | input | 12 | Ticks to wait before the window |
| length_i | input | 12 | Window length in ticks |
| offset_i | input | 6 | Signed calibration offset in dB |
| thr_we_i | input | 1 | Load strobe for the threshold |
| thr_i | input | 8 | Threshold value |
| done_o | output | 1 | One-cycle measurement completion pulse |
| busy_o | output | 1 | Channel busy result |
| rssi_o | output | 7 | Latched calibrated strength code |

## Verification
The hardest conditions to reach from the ports are a start pulse that arrives in the middle of a window, and the exact edge between the delay phase and the window. Delay ticks must not add to the sum, and a start pulse inside the window must be ignored. The bench drives the timebase itself, one tick per few clocks. It feeds a marker sample during the delay ticks, so that any wrong accumulation shows up in the average. It inserts a start pulse between two window ticks. It then keeps ticking after the result to confirm that no second measurement has begun.

// File: rtl/cca_pkg.sv
package cca_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_MEAS = 2'd2,
    ST_DIV  = 2'd3
  } cca_state_e;
endpackage

// File: rtl/cca_window.sv
module cca_window
  import cca_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int TIME_W   = 12,
  parameter int SUM_W    = SAMPLE_W + TIME_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                tick_i,
  input  logic [TIME_W-1:0]   delay_i,
  input  logic [TIME_W-1:0]   length_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                div_done_i,
  output cca_state_e          state_o,
  output logic                div_start_o,
  output logic [SUM_W-1:0]    sum_o,
  output logic [TIME_W-1:0]   count_o
);
  cca_state_e          st_q;
  logic [TIME_W-1:0]   cnt_q;
  logic [TIME_W-1:0]   len_q;
  logic [SUM_W-1:0]    sum_q;
  logic                kick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= TIME_W'(1);
      sum_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_DLY;
          cnt_q <= delay_i;
          len_q <= (length_i == '0) ? TIME_W'(1) : length_i;
        end
        ST_DLY: begin
          if (cnt_q == '0) begin
            st_q  <= ST_MEAS;
            cnt_q <= len_q;
            sum_q <= '0;
          end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_MEAS: if (tick_i) begin
          sum_q <= sum_q + SUM_W'(smp_i);
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == TIME_W'(1)) begin
            st_q   <= ST_DIV;
            kick_q <= 1'b1;
          end
        end
        ST_DIV: if (div_done_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = st_q;
  assign div_start_o = kick_q;
  assign sum_o       = sum_q;
  assign count_o     = len_q;
endmodule

// File: rtl/cca_div.sv
module cca_div #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             valid_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q;
  logic [CNT_W-1:0] iter_q;
  logic             run_q;
  logic             valid_q;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   diff;
  logic             ge;

  // restoring division, one quotient bit per cycle
  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    ge      = shifted >= {1'b0, den_i};
    diff    = shifted - {1'b0, den_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q   <= '0;
      rem_q   <= '0;
      iter_q  <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        quo_q  <= num_i;
        rem_q  <= '0;
        iter_q <= CNT_W'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], ge};
        iter_q <= iter_q - 1'b1;
        if (iter_q == CNT_W'(1)) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign quo_o   = quo_q;
endmodule

// File: rtl/cca_calib.sv
module cca_calib #(
  parameter int SAMPLE_W = 8,
  parameter int OFF_W    = 6,
  parameter int CODE_W   = 7
) (
  input  logic [SAMPLE_W-1:0] raw_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [SAMPLE_W-1:0] thr_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                busy_o
);
  localparam int EXT_W = SAMPLE_W + 2;
  localparam logic signed [EXT_W-1:0] MAX_C = EXT_W'((1 << CODE_W) - 1);

  logic signed [EXT_W-1:0] raw_s;
  logic signed [EXT_W-1:0] off_s;
  logic signed [EXT_W-1:0] sum_s;

  always_comb begin
    raw_s = signed'({2'b00, raw_i});
    off_s = signed'({{(EXT_W-OFF_W){off_i[OFF_W-1]}}, off_i});
    sum_s = raw_s + off_s;
    if (sum_s < 0)          code_o = '0;
    else if (sum_s > MAX_C) code_o = '1;
    else                    code_o = sum_s[CODE_W-1:0];
    busy_o = SAMPLE_W'(code_o) > thr_i;
  end
endmodule

// File: rtl/cca_eval.sv
module cca_eval
  import cca_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int TIME_W   = 12,
  parameter int OFF_W    = 6,
  parameter int CODE_W   = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic                pkt_end_i,
  input  logic [TIME_W-1:0]   delay_i,
  input  logic [TIME_W-1:0]   length_i,
  input  logic [OFF_W-1:0]    offset_i,
  input  logic                thr_we_i,
  input  logic [SAMPLE_W-1:0] thr_i,
  output logic                done_o,
  output logic                busy_o,
  output logic [CODE_W-1:0]   rssi_o
);
  localparam int SUM_W = SAMPLE_W + TIME_W;

  cca_state_e          st;
  logic [SAMPLE_W-1:0] held_q;
  logic [SAMPLE_W-1:0] thr_q;
  logic [SUM_W-1:0]    win_sum;
  logic [TIME_W-1:0]   win_cnt;
  logic                div_start;
  logic                div_valid;
  logic [SUM_W-1:0]    quo;
  logic [SAMPLE_W-1:0] avg;
  logic [SAMPLE_W-1:0] cal_in;
  logic [CODE_W-1:0]   cal_code;
  logic                cal_busy;
  logic                done_q;
  logic                busy_q;
  logic [CODE_W-1:0]   rssi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      thr_q  <= '1;
    end else begin
      if (sample_valid_i) held_q <= sample_i;
      if (thr_we_i)       thr_q  <= thr_i;
    end
  end

  cca_window #(.SAMPLE_W(SAMPLE_W), .TIME_W(TIME_W), .SUM_W(SUM_W)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .delay_i    (delay_i),
    .length_i   (length_i),
    .smp_i      (held_q),
    .div_done_i (div_valid),
    .state_o    (st),
    .div_start_o(div_start),
    .sum_o      (win_sum),
    .count_o    (win_cnt)
  );

  cca_div #(.NUM_W(SUM_W), .DEN_W(TIME_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (win_sum),
    .den_i  (win_cnt),
    .valid_o(div_valid),
    .quo_o  (quo)
  );

  assign avg    = (|quo[SUM_W-1:SAMPLE_W]) ? '1 : quo[SAMPLE_W-1:0];
  assign cal_in = div_valid ? avg : held_q;

  cca_calib #(.SAMPLE_W(SAMPLE_W), .OFF_W(OFF_W), .CODE_W(CODE_W)) u_calib (
    .raw_i (cal_in),
    .off_i (offset_i),
    .thr_i (thr_q),
    .code_o(cal_code),
    .busy_o(cal_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      busy_q <= 1'b0;
      rssi_q <= '0;
    end else begin
      done_q <= div_valid;
      if (div_valid) begin
        busy_q <= cal_busy;
        rssi_q <= cal_code;
      end else if (pkt_end_i) begin
        rssi_q <= cal_code;
      end
    end
  end

  assign done_o = done_q;
  assign busy_o = busy_q;
  assign rssi_o = rssi_q;
endmodule

// File: rtl/cca_eval_chk.sv
module cca_eval_chk
  import cca_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int CODE_W   = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                pkt_end_i,
  input logic                done_o,
  input logic                busy_o,
  input logic [CODE_W-1:0]   rssi_o,
  input logic [SAMPLE_W-1:0] thr_q,
  input cca_state_e          st
);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(busy_o) |-> done_o);

  assert_strict_cmp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o == (SAMPLE_W'(rssi_o) > $past(thr_q))));

  assert_rssi_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rssi_o) |-> (done_o || $past(pkt_end_i)));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_MEAS && start_i) |=> (st != ST_DLY));

  assert_done_after_div_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(st) == ST_DIV));
endmodule

bind cca_eval cca_eval_chk #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .pkt_end_i(pkt_end_i),
  .done_o   (done_o),
  .busy_o   (busy_o),
  .rssi_o   (rssi_o),
  .thr_q    (thr_q),
  .st       (st)
);

// File: tb/cca_eval_bench.sv
`timescale 1ns/1ps
module cca_eval_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_valid_i = 1'b0;
  logic [7:0] sample_i = '0;
  logic       tick_i = 1'b0;
  logic       start_i = 1'b0;
  logic       pkt_end_i = 1'b0;
  logic [11:0] delay_i = '0;
  logic [11:0] length_i = '0;
  logic [5:0] offset_i = '0;
  logic       thr_we_i = 1'b0;
  logic [7:0] thr_i = '0;
  logic       done_o;
  logic       busy_o;
  logic [6:0] rssi_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  cca_eval u_cca_eval (.*);

  // delay(12) len(12) off(6) thr(8) s0 s1 s2 s3
  localparam int NV = 8;
  localparam logic [69:0] VECS [NV] = '{
    {12'd0, 12'd4, 6'h00, 8'd50,  8'd40,  8'd60,  8'd50,  8'd70},
    {12'd3, 12'd4, 6'h00, 8'd55,  8'd40,  8'd60,  8'd50,  8'd70},
    {12'd2, 12'd3, 6'h3B, 8'd40,  8'd40,  8'd41,  8'd45,  8'd99},
    {12'd0, 12'd0, 6'h03, 8'd60,  8'd60,  8'd1,   8'd1,   8'd1},
    {12'd1, 12'd2, 6'h1F, 8'd120, 8'd110, 8'd115, 8'd0,   8'd0},
    {12'd0, 12'd4, 6'h20, 8'd0,   8'd10,  8'd20,  8'd30,  8'd5},
    {12'd0, 12'd5, 6'h00, 8'd100, 8'd200, 8'd200, 8'd200, 8'd200},
    {12'd0, 12'd3, 6'h00, 8'd126, 8'd127, 8'd127, 8'd127, 8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_cal(input int avg, input logic [5:0] off);
    int v;
    v = avg + int'($signed(off));
    if (v < 0) v = 0;
    if (v > 127) v = 127;
    return v;
  endfunction

  task automatic set_sample(input logic [7:0] s);
    @(negedge clk_i);
    sample_i = s;
    sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic do_tick(input logic [7:0] s);
    set_sample(s);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic load_thr(input logic [7:0] t);
    @(negedge clk_i);
    thr_i = t;
    thr_we_i = 1'b1;
    @(negedge clk_i);
    thr_we_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // waits for done; returns result and checks the pulse is one cycle wide
  task automatic wait_done(output logic got, output logic b, output logic [6:0] r);
    got = 1'b0; b = 1'b0; r = '0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk_i);
      if (done_o) begin
        got = 1'b1; b = busy_o; r = rssi_o;
        break;
      end
    end
    chk(got, "R8 done seen", int'(got), 1);
    @(negedge clk_i);
    chk(!done_o, "R8 done one cycle", int'(done_o), 0);
  endtask

  task automatic run_meas(input int d, input int n, input logic [5:0] off,
                          input logic [7:0] s0, input logic [7:0] s1,
                          input logic [7:0] s2, input logic [7:0] s3,
                          output logic got, output logic b, output logic [6:0] r);
    logic [7:0] sv [4];
    int nt;
    sv[0] = s0; sv[1] = s1; sv[2] = s2; sv[3] = s3;
    nt = (n == 0) ? 1 : n;
    offset_i = off;
    delay_i  = 12'(d);
    length_i = 12'(n);
    pulse_start();
    @(negedge clk_i);
    for (int k = 0; k < d + nt; k++)
      do_tick((k < d) ? 8'hEE : sv[(k - d) % 4]);
    wait_done(got, b, r);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic got, b;
    logic [6:0] r;
    logic [69:0] v;
    int d, n, sum, nt, avg, ecal;
    logic [5:0] off;
    logic [7:0] thr;
    logic [7:0] sv [4];

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(done_o == 1'b0, "R1 done reset", int'(done_o), 0);
    chk(busy_o == 1'b0, "R1 busy reset", int'(busy_o), 0);
    chk(rssi_o == 7'd0, "R1 rssi reset", int'(rssi_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7 default threshold 0xFF never busy, even at full-scale strength
    run_meas(0, 1, 6'h1F, 8'd127, 8'd127, 8'd127, 8'd127, got, b, r);
    chk(b == 1'b0, "R7 default thr clear", int'(b), 0);
    chk(r == 7'd127, "R5 R7 full scale code", int'(r), 127);

    // table walk (R2 R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      v   = VECS[i];
      d   = int'(v[69:58]);
      n   = int'(v[57:46]);
      off = v[45:40];
      thr = v[39:32];
      sv[0] = v[31:24]; sv[1] = v[23:16]; sv[2] = v[15:8]; sv[3] = v[7:0];
      nt  = (n == 0) ? 1 : n;
      sum = 0;
      for (int k = 0; k < nt; k++) sum += int'(sv[k % 4]);
      avg  = sum / nt;
      ecal = clamp_cal(avg, off);
      load_thr(thr);
      run_meas(d, n, off, sv[0], sv[1], sv[2], sv[3], got, b, r);
      chk(int'(r) == ecal, $sformatf("R2 R3 R4 R5 vec%0d rssi", i), int'(r), ecal);
      chk(b == (ecal > int'(thr)), $sformatf("R6 vec%0d busy", i), int'(b),
          int'(ecal > int'(thr)));
    end

    // R9 start during window ignored
    load_thr(8'd10);
    offset_i = 6'h00; delay_i = 12'd0; length_i = 12'd2;
    pulse_start();
    @(negedge clk_i);
    do_tick(8'd30);
    pulse_start();
    do_tick(8'd50);
    wait_done(got, b, r);
    chk(r == 7'd40, "R9 result unaffected", int'(r), 40);
    begin
      int extra = 0;
      for (int k = 0; k < 4; k++) begin
        do_tick(8'd90);
        for (int c = 0; c < 30; c++) begin
          @(negedge clk_i);
          if (done_o) extra++;
        end
      end
      chk(extra == 0, "R9 no second result", extra, 0);
      chk(rssi_o == 7'd40, "R9 rssi kept", int'(rssi_o), 40);
    end

    // R10 packet-end latch and hold
    offset_i = 6'h3C; // -4
    set_sample(8'd100);
    @(negedge clk_i);
    pkt_end_i = 1'b1;
    @(negedge clk_i);
    pkt_end_i = 1'b0;
    chk(rssi_o == 7'd96, "R10 pkt end latch", int'(rssi_o), 96);
    set_sample(8'd50);
    repeat (3) @(negedge clk_i);
    chk(rssi_o == 7'd96, "R10 rssi holds", int'(rssi_o), 96);
    chk(busy_o == 1'b1, "R8 busy holds after pkt end", int'(busy_o), 1);
    offset_i = 6'h20; // -32
    set_sample(8'd5);
    pkt_end_i = 1'b1;
    @(negedge clk_i);
    pkt_end_i = 1'b0;
    chk(rssi_o == 7'd0, "R10 R5 pkt end clamp low", int'(rssi_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule